// File: doc/BRIEF.md
# Audio Codec Bring-up and Control-Register Sequencer

This block starts an external audio codec and then keeps its volume registers in step with the user controls. After system reset it keeps the codec's reset pin low for a fixed number of clock cycles, counted by a timer. It then releases the pin and waits for the codec to report that it is ready. Next it issues a short fixed list of register writes, one of which sets the PCM sample rate to 4000 (0x0FA0). Finally it writes the speaker and microphone volume registers from the switch inputs and raises a flag that allows audio streaming to start.

From then on the block compares each volume word, built from a level field and a mute bit, with the value it last sent. Any difference produces a single write. All commands go out one at a time as an address/data pair with a valid flag, and the pair is held until the frame controller that serializes it returns an acknowledge. The system reset `rst_n` is asynchronous and active low, and is expected to be deasserted synchronously to `clk`.

Top module: `codec_cmd_seq`

## Requirements
- R1: While `rst_n` is low, `codec_rst_n_o` is low, `cmd_valid_o` is low and `stream_en_o` is low. After `rst_n` rises, `codec_rst_n_o` stays low for exactly `RST_HOLD_CYC` rising clock edges and then goes high.
- R2: No command is presented until `codec_ready_i` has been sampled high after `codec_rst_n_o` went high.
- R3: The first two commands after ready are, in this order: address 0x18 with data 0x0808, then address 0x2C with data 0x0FA0 (the PCM rate of 4000).
- R4: After these two, the speaker register and then the microphone register are written with the current input values. `stream_en_o` rises only after both writes are acknowledged, and it stays high until reset.
- R5: A speaker write uses address 0x02. Its data has the mute bit at bit 15, the level in bits [LVL_W-1:0] and again in bits [8+LVL_W-1:8], and all other bits zero.
- R6: A microphone write uses address 0x0E. Its data has the mute bit at bit 15, the level in bits [LVL_W-1:0], and all other bits zero.
- R7: Once `cmd_valid_o` is high, it stays high and `cmd_addr_o`/`cmd_data_o` stay stable until `cmd_ack_i` is sampled high. `cmd_valid_o` is low in the cycle after that sample.
- R8: After initialization, each change of a volume word produces exactly one write of that register. Inputs that do not change the word produce no write.
- R9: Changes made while a command is outstanding are merged. They give at most one follow-up write, carrying the latest value, and no write at all if the word has returned to the value in flight.
- R10: When both registers need a write at the same time, the speaker register is written first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| codec_rst_n_o | output | 1 | Active-low reset to the codec |
| codec_ready_i | input | 1 | Codec reports that it is ready |
| spk_level_i | input | LVL_W | Speaker attenuation level |
| spk_mute_i | input | 1 | Speaker mute |
| mic_level_i | input | LVL_W | Microphone gain level |
| mic_mute_i | input | 1 | Microphone mute |
| cmd_addr_o | output | 7 | Register address of the pending command |
| cmd_data_o | output | 16 | Register data of the pending command |
| cmd_valid_o | output | 1 | Command is pending |
| cmd_ack_i | input | 1 | Frame controller accepted the command |
| stream_en_o | output | 1 | Initialization complete; PCM streaming may run |

## Verification
A wrong shadow or dirty bit appears on the command port as a missing, duplicated or stale write. The bench sees it within a few cycles of the triggering switch change, because every sweep step expects exactly one write followed by a quiet window. A corrupted init index or state shows up in the first four commands as a wrong address, a wrong data value or a wrong order, or as `stream_en_o` rising too early. An off-by-one in the reset timer moves the rising edge of `codec_rst_n_o` by one cycle, and the bench counts that edge exactly.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int N_INIT = 2;

  localparam logic [ADDR_W-1:0] SPK_ADDR      = 7'h02;
  localparam logic [ADDR_W-1:0] MIC_ADDR      = 7'h0E;
  localparam logic [ADDR_W-1:0] PCM_GAIN_ADDR = 7'h18;
  localparam logic [ADDR_W-1:0] RATE_ADDR     = 7'h2C;
  localparam logic [DATA_W-1:0] PCM_GAIN_VAL  = 16'h0808;
  localparam logic [DATA_W-1:0] RATE_VAL      = 16'h0FA0;

  typedef enum logic [1:0] {
    ST_HOLD,
    ST_WAIT_RDY,
    ST_INIT,
    ST_RUN
  } seq_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } reg_cmd_t;

  // Fixed bring-up writes, issued in index order.
  function automatic reg_cmd_t init_entry(input logic [7:0] idx);
    reg_cmd_t e;
    case (idx)
      8'd0:    e = '{PCM_GAIN_ADDR, PCM_GAIN_VAL};
      default: e = '{RATE_ADDR, RATE_VAL};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/cmd_seq_hold_timer.sv
module cmd_seq_hold_timer #(
  parameter int unsigned CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q >= CNT_W'(CYCLES - 1));
  assign cnt_en = en && !done;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cmd_seq_vol_word.sv
module cmd_seq_vol_word
  import cmd_seq_pkg::*;
#(
  parameter int LVL_W  = 5,
  parameter bit STEREO = 1'b1
) (
  input  logic [LVL_W-1:0]  level,
  input  logic              mute,
  output logic [DATA_W-1:0] word
);
  generate
    if (STEREO) begin : g_stereo
      always_comb begin
        word             = '0;
        word[DATA_W-1]   = mute;
        word[LVL_W-1:0]  = level;
        word[8 +: LVL_W] = level;
      end
    end else begin : g_mono
      always_comb begin
        word            = '0;
        word[DATA_W-1]  = mute;
        word[LVL_W-1:0] = level;
      end
    end
  endgenerate
endmodule

// File: rtl/codec_cmd_seq.sv
module codec_cmd_seq
  import cmd_seq_pkg::*;
#(
  parameter int unsigned RST_HOLD_CYC = 1024,
  parameter int          LVL_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              codec_rst_n_o,
  input  logic              codec_ready_i,
  input  logic [LVL_W-1:0]  spk_level_i,
  input  logic              spk_mute_i,
  input  logic [LVL_W-1:0]  mic_level_i,
  input  logic              mic_mute_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ack_i,
  output logic              stream_en_o
);
  localparam int IDX_W = $clog2(N_INIT + 1);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              cmd_load;
  logic [DATA_W-1:0] spk_word, mic_word;
  logic [DATA_W-1:0] spk_shadow_q, mic_shadow_q;
  logic              spk_dirty_q, mic_dirty_q;
  logic              spk_load, mic_load;
  logic              spk_pend, mic_pend;
  logic              stream_q, stream_d;
  logic              hold_done;
  reg_cmd_t          init_cmd;

  cmd_seq_hold_timer #(.CYCLES(RST_HOLD_CYC)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (state_q == ST_HOLD),
    .done (hold_done)
  );

  cmd_seq_vol_word #(.LVL_W(LVL_W), .STEREO(1'b1)) u_spk_word (
    .level(spk_level_i),
    .mute (spk_mute_i),
    .word (spk_word)
  );

  cmd_seq_vol_word #(.LVL_W(LVL_W), .STEREO(1'b0)) u_mic_word (
    .level(mic_level_i),
    .mute (mic_mute_i),
    .word (mic_word)
  );

  assign spk_pend = spk_dirty_q || (spk_word != spk_shadow_q);
  assign mic_pend = mic_dirty_q || (mic_word != mic_shadow_q);
  assign init_cmd = init_entry(8'(idx_q));

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    valid_d  = valid_q;
    addr_d   = addr_q;
    data_d   = data_q;
    stream_d = stream_q;
    cmd_load = 1'b0;
    spk_load = 1'b0;
    mic_load = 1'b0;
    if (valid_q && cmd_ack_i) begin
      valid_d = 1'b0;
    end
    case (state_q)
      ST_HOLD: begin
        if (hold_done) state_d = ST_WAIT_RDY;
      end
      ST_WAIT_RDY: begin
        if (codec_ready_i) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (!valid_q) begin
          if (idx_q == IDX_W'(N_INIT)) begin
            state_d = ST_RUN;
          end else begin
            cmd_load = 1'b1;
            valid_d  = 1'b1;
            addr_d   = init_cmd.addr;
            data_d   = init_cmd.data;
            idx_d    = idx_q + 1'b1;
          end
        end
      end
      default: begin
        if (!valid_q) begin
          if (spk_pend) begin
            cmd_load = 1'b1;
            spk_load = 1'b1;
            valid_d  = 1'b1;
            addr_d   = SPK_ADDR;
            data_d   = spk_word;
          end else if (mic_pend) begin
            cmd_load = 1'b1;
            mic_load = 1'b1;
            valid_d  = 1'b1;
            addr_d   = MIC_ADDR;
            data_d   = mic_word;
          end else begin
            stream_d = 1'b1;
          end
        end
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HOLD;
      idx_q    <= '0;
      valid_q  <= 1'b0;
      stream_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      valid_q  <= valid_d;
      stream_q <= stream_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cmd_load) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spk_shadow_q <= '0;
      spk_dirty_q  <= 1'b1;
    end else if (spk_load) begin
      spk_shadow_q <= spk_word;
      spk_dirty_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mic_shadow_q <= '0;
      mic_dirty_q  <= 1'b1;
    end else if (mic_load) begin
      mic_shadow_q <= mic_word;
      mic_dirty_q  <= 1'b0;
    end
  end

  assign codec_rst_n_o = (state_q != ST_HOLD);
  assign cmd_valid_o   = valid_q;
  assign cmd_addr_o    = addr_q;
  assign cmd_data_o    = data_q;
  assign stream_en_o   = stream_q;
endmodule

// File: rtl/codec_cmd_seq_chk.sv
module codec_cmd_seq_chk
  import cmd_seq_pkg::*;
#(
  parameter int unsigned RST_HOLD_CYC = 1024,
  parameter int          LVL_W        = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              codec_rst_n_o,
  input logic              codec_ready_i,
  input logic [LVL_W-1:0]  spk_level_i,
  input logic              spk_mute_i,
  input logic [LVL_W-1:0]  mic_level_i,
  input logic              mic_mute_i,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [DATA_W-1:0] cmd_data_o,
  input logic              cmd_valid_o,
  input logic              cmd_ack_i,
  input logic              stream_en_o
);
  logic [31:0] low_cnt;
  logic        seen_ready;
  logic        valid_prev;
  logic [2:0]  n_launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      seen_ready <= 1'b0;
      valid_prev <= 1'b0;
      n_launch   <= '0;
    end else begin
      if (!codec_rst_n_o) low_cnt <= low_cnt + 1;
      if (codec_rst_n_o && codec_ready_i) seen_ready <= 1'b1;
      valid_prev <= cmd_valid_o;
      if (cmd_valid_o && !valid_prev && n_launch != 3'd7) n_launch <= n_launch + 3'd1;
    end
  end

  AST_RST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codec_rst_n_o) |-> low_cnt == RST_HOLD_CYC); // R1
  AST_NO_CMD_BEFORE_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> seen_ready); // R2
  AST_RATE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !valid_prev && n_launch == 3'd1) |-> (cmd_addr_o == RATE_ADDR && cmd_data_o == RATE_VAL)); // R3
  AST_STREAM_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    stream_en_o |-> n_launch >= 3'd4); // R4
  AST_STREAM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stream_en_o |=> stream_en_o); // R4
  AST_SPK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid_o) && cmd_addr_o == SPK_ADDR) |->
      (cmd_data_o[DATA_W-1] == $past(spk_mute_i) && cmd_data_o[LVL_W-1:0] == $past(spk_level_i))); // R5
  AST_MIC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid_o) && cmd_addr_o == MIC_ADDR) |->
      (cmd_data_o[DATA_W-1] == $past(mic_mute_i) && cmd_data_o[LVL_W-1:0] == $past(mic_level_i))); // R6
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ack_i) |=> (cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_data_o))); // R7
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_ack_i) |=> !cmd_valid_o); // R7
endmodule

bind codec_cmd_seq codec_cmd_seq_chk #(
  .RST_HOLD_CYC(RST_HOLD_CYC),
  .LVL_W       (LVL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .codec_rst_n_o(codec_rst_n_o),
  .codec_ready_i(codec_ready_i),
  .spk_level_i  (spk_level_i),
  .spk_mute_i   (spk_mute_i),
  .mic_level_i  (mic_level_i),
  .mic_mute_i   (mic_mute_i),
  .cmd_addr_o   (cmd_addr_o),
  .cmd_data_o   (cmd_data_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ack_i    (cmd_ack_i),
  .stream_en_o  (stream_en_o)
);

// File: tb/tb_codec_cmd_seq.sv
module tb_codec_cmd_seq;
  import cmd_seq_pkg::*;

  localparam int unsigned HOLD = 12;
  localparam int          LVL  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              codec_rst_n_o;
  logic              codec_ready_i = 1'b0;
  logic [LVL-1:0]    spk_level_i = '0;
  logic              spk_mute_i = 1'b0;
  logic [LVL-1:0]    mic_level_i = '0;
  logic              mic_mute_i = 1'b0;
  logic [ADDR_W-1:0] cmd_addr_o;
  logic [DATA_W-1:0] cmd_data_o;
  logic              cmd_valid_o;
  logic              cmd_ack_i = 1'b0;
  logic              stream_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  codec_cmd_seq #(.RST_HOLD_CYC(HOLD), .LVL_W(LVL)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .codec_rst_n_o(codec_rst_n_o),
    .codec_ready_i(codec_ready_i),
    .spk_level_i  (spk_level_i),
    .spk_mute_i   (spk_mute_i),
    .mic_level_i  (mic_level_i),
    .mic_mute_i   (mic_mute_i),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_data_o   (cmd_data_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ack_i    (cmd_ack_i),
    .stream_en_o  (stream_en_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] spk_exp(input int lvl, input bit m);
    return 16'((m ? 32768 : 0) + lvl * 256 + lvl);
  endfunction

  function automatic logic [15:0] mic_exp(input int lvl, input bit m);
    return 16'((m ? 32768 : 0) + lvl);
  endfunction

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (cmd_valid_o) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_ack(input string req);
    cmd_ack_i = 1'b1;
    @(negedge clk);
    cmd_ack_i = 1'b0;
    chk(!cmd_valid_o, req, "valid low after ack", cmd_valid_o, 0);
  endtask

  task automatic expect_cmd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input string req);
    bit got;
    bit stable_ok;
    wait_valid(got);
    chk(got, req, "command presented", got, 1);
    if (got) begin
      chk(cmd_addr_o == a, req, "address", cmd_addr_o, a);
      chk(cmd_data_o == d, req, "data", cmd_data_o, d);
      stable_ok = 1'b1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (!cmd_valid_o || cmd_addr_o != a || cmd_data_o != d) stable_ok = 1'b0;
      end
      chk(stable_ok, "R7", "hold until ack", stable_ok, 1);
      do_ack("R7");
    end
  endtask

  task automatic expect_none(input int n, input string req);
    bit quiet;
    quiet = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmd_valid_o) quiet = 1'b0;
    end
    chk(quiet, req, "no command expected", !quiet, 0);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int  cnt;
    bit  got;
    spk_level_i = 5'd5;
    mic_level_i = 5'd3;
    repeat (3) @(negedge clk);
    chk(!codec_rst_n_o && !cmd_valid_o && !stream_en_o, "R1", "reset state",
        {codec_rst_n_o, cmd_valid_o, stream_en_o}, 0);
    rst_n = 1'b1;
    cnt = 0;
    while (!codec_rst_n_o && cnt < 5000) begin
      @(posedge clk);
      #1;
      cnt++;
    end
    chk(cnt == HOLD, "R1", "codec reset hold edges", cnt, HOLD);
    @(negedge clk);

    // R2: ready withheld, nothing may be issued
    expect_none(20, "R2");
    codec_ready_i = 1'b1;

    // R3: fixed bring-up writes
    expect_cmd(PCM_GAIN_ADDR, PCM_GAIN_VAL, "R3");
    expect_cmd(RATE_ADDR, RATE_VAL, "R3");

    // R4: initial volume writes, streaming enabled only afterwards
    chk(!stream_en_o, "R4", "stream before volume writes", stream_en_o, 0);
    expect_cmd(SPK_ADDR, spk_exp(5, 0), "R4");
    chk(!stream_en_o, "R4", "stream before mic write", stream_en_o, 0);
    expect_cmd(MIC_ADDR, mic_exp(3, 0), "R4");
    @(negedge clk);
    @(negedge clk);
    chk(stream_en_o, "R4", "stream after init", stream_en_o, 1);
    expect_none(10, "R8");

    // R5 / R8: full speaker sweep
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < 32; l++) begin
        spk_level_i = 5'(l);
        spk_mute_i  = m[0];
        expect_cmd(SPK_ADDR, spk_exp(l, m[0]), "R5");
        expect_none(4, "R8");
      end
    end

    // R6 / R8: full microphone sweep
    for (int m = 0; m < 2; m++) begin
      for (int l = 0; l < 32; l++) begin
        mic_level_i = 5'(l);
        mic_mute_i  = m[0];
        expect_cmd(MIC_ADDR, mic_exp(l, m[0]), "R6");
        expect_none(4, "R8");
      end
    end

    // R8: rewriting identical values changes nothing
    spk_level_i = 5'd31;
    spk_mute_i  = 1'b1;
    mic_level_i = 5'd31;
    mic_mute_i  = 1'b1;
    expect_none(10, "R8");

    // R9: several changes during an outstanding write merge into one
    spk_level_i = 5'd10;
    spk_mute_i  = 1'b0;
    wait_valid(got);
    chk(got && cmd_data_o == spk_exp(10, 0), "R9", "first merged write", cmd_data_o, spk_exp(10, 0));
    spk_level_i = 5'd11;
    @(negedge clk);
    spk_level_i = 5'd12;
    spk_mute_i  = 1'b1;
    @(negedge clk);
    chk(cmd_data_o == spk_exp(10, 0), "R7", "data held while pending", cmd_data_o, spk_exp(10, 0));
    do_ack("R9");
    expect_cmd(SPK_ADDR, spk_exp(12, 1), "R9");
    expect_none(10, "R9");

    // R9: change and revert during a write causes no follow-up
    spk_level_i = 5'd20;
    spk_mute_i  = 1'b0;
    wait_valid(got);
    chk(got && cmd_data_o == spk_exp(20, 0), "R9", "write before revert", cmd_data_o, spk_exp(20, 0));
    spk_level_i = 5'd21;
    @(negedge clk);
    spk_level_i = 5'd20;
    @(negedge clk);
    do_ack("R9");
    expect_none(10, "R9");

    // R10: simultaneous changes, speaker first
    spk_level_i = 5'd1;
    spk_mute_i  = 1'b1;
    mic_level_i = 5'd2;
    mic_mute_i  = 1'b0;
    expect_cmd(SPK_ADDR, spk_exp(1, 1), "R10");
    expect_cmd(MIC_ADDR, mic_exp(2, 0), "R10");
    expect_none(10, "R10");

    chk(stream_en_o, "R4", "stream stays high", stream_en_o, 1);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule